// File: doc/BRIEF.md
# Interlace-Capable Raster Timing Generator

This block produces the raster timing for a text or bitmap display controller: horizontal and vertical sync, a display-enable strobe, the number of the frame line being drawn and a field flag. A horizontal counter steps once per clock and a vertical counter steps once per line. Each vertical pass is one refresh of the screen in progressive mode and one field in interlaced mode.

One bit of a control register chooses the mode. In progressive mode every active line is drawn on every pass. In interlaced mode a frame takes two passes. The first field carries the odd frame lines and the second carries the even ones. On the second field the vertical sync edge moves half a line later, so the two fields interleave on the screen and give twice the vertical resolution. The register is reached through a narrow write port. A write with the select low loads a register pointer, and a write with the select high loads the register it points at. A mode change waits for the next pass boundary, so no field is ever drawn half in one mode and half in the other.

Top module: `vid_raster_gen`

## Requirements
- R1: Each line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks (24 by default), counting horizontal positions from 0. `hsync_o` is at its active level (HS_ACT, default 1) for positions H_ACTIVE+H_FRONT up to H_ACTIVE+H_FRONT+H_SYNC-1, and inactive at every other position.
- R2: In progressive mode each pass lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. Of these, V_ACTIVE lines (200 by default) are active, and each one is drawn on every pass with `frame_line_o` equal to its line index 0..199. `vsync_o` (active level VS_ACT, default 1) is active from position 0 of line V_ACTIVE+V_FRONT to the end of line V_ACTIVE+V_FRONT+V_SYNC-1.
- R3: `de_o` is high only when the horizontal position is below H_ACTIVE and the line is below V_ACTIVE. `frame_line_o` is 0 on every line outside the active lines.
- R4: A write with `reg_sel_i`=0 loads the pointer from `reg_wdata_i`. A write with `reg_sel_i`=1 while the pointer equals CTRL_ADDR (default 8'h05) stores `reg_wdata_i[0]` as the interlace request. `reg_rdata_o` shows that bit in bit 0 with all other bits 0 while the pointer is CTRL_ADDR, and reads 0 at every other pointer. A data write at any other pointer changes nothing.
- R5: A new interlace request takes effect only from the first clock of the next vertical pass. Until then, timing and line numbering continue in the old mode.
- R6: `field_o` is 0 in progressive mode. The first pass after interlace takes effect has `field_o`=0, and the flag then toggles at every pass boundary while interlace stays on.
- R7: In interlaced mode, active line n of the pass gives `frame_line_o` = 2n+1 when `field_o`=0 and 2n when `field_o`=1.
- R8: When `field_o`=1, `vsync_o` turns active at horizontal position H_TOTAL/2 of line V_ACTIVE+V_FRONT and turns inactive at position H_TOTAL/2 of line V_ACTIVE+V_FRONT+V_SYNC. When `field_o`=0, the vsync lines are the same as in R2.
- R9: Two consecutive interlaced fields together present all 2*V_ACTIVE (400) frame lines.
- R10: During reset the counters, field flag, mode, request and pointer are all 0. The outputs are then: sync signals inactive, `de_o`=1 at position 0 of line 0, `frame_line_o`=0, `field_o`=0 and `reg_rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0: write the pointer, 1: write the pointed register |
| reg_wdata_i | input | RW (8) | Write data |
| reg_rdata_o | output | RW (8) | Contents of the pointed register |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable |
| frame_line_o | output | LW (9) | Frame line being drawn |
| field_o | output | 1 | Field flag |

## Verification
The timing runs for several whole passes in progressive mode, then in interlaced mode, then in progressive mode again, and every output is compared on every clock with a predictor that models the timing. The switch to interlace is written in the middle of a pass, which separates a design that defers the mode change from one that applies it at once. Register writes and reads at the control pointer and at an unused pointer separate correct address decoding and masking of unused bits from a decoder that leaks. Coverage maps of all 200 progressive lines and all 400 interlaced frame lines expose odd/even swaps and numbering that doubles lines or leaves gaps.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
   typedef enum logic {
      SEL_POINTER = 1'b0,
      SEL_DATA    = 1'b1
   } reg_sel_e;

   typedef enum logic {
      FIELD_ODD  = 1'b0,
      FIELD_EVEN = 1'b1
   } field_e;
endpackage

// File: rtl/vrg_regs.sv
module vrg_regs
   import vrg_pkg::*;
#(
   parameter int          RW        = 8,
   parameter logic [RW-1:0] CTRL_ADDR = 8'h05
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_i,
   input  logic          sel_i,
   input  logic [RW-1:0] wdata_i,
   output logic [RW-1:0] rdata_o,
   output logic          ilace_req_o
);
   logic [RW-1:0] ptr_q;
   logic          req_q;
   logic          at_ctrl;

   assign at_ctrl = (ptr_q == CTRL_ADDR);

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_q <= '0;
         req_q <= 1'b0;
      end else if (wr_i) begin
         if (reg_sel_e'(sel_i) == SEL_POINTER)
            ptr_q <= wdata_i;
         else if (at_ctrl)
            req_q <= wdata_i[0];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (at_ctrl)
         rdata_o[0] = req_q;
   end

   assign ilace_req_o = req_q;
endmodule

// File: rtl/vrg_hcount.sv
module vrg_hcount #(
   parameter int   H_ACTIVE = 16,
   parameter int   H_FRONT  = 2,
   parameter int   H_SYNC   = 4,
   parameter int   H_BACK   = 2,
   parameter bit   HS_ACT   = 1'b1,
   localparam int  H_TOTAL  = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
   localparam int  HW       = $clog2(H_TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [HW-1:0] hpos_o,
   output logic          h_act_o,
   output logic          line_end_o,
   output logic          hsync_o
);
   localparam int HS_START = H_ACTIVE + H_FRONT;
   localparam int HS_STOP  = HS_START + H_SYNC;

   logic [HW-1:0] hc_q;
   logic          hs_on;

   always_ff @(posedge clk) begin
      if (rst)
         hc_q <= '0;
      else if (line_end_o)
         hc_q <= '0;
      else
         hc_q <= hc_q + 1'b1;
   end

   assign line_end_o = (hc_q == HW'(H_TOTAL - 1));
   assign h_act_o    = (hc_q < HW'(H_ACTIVE));
   assign hs_on      = (hc_q >= HW'(HS_START)) && (hc_q < HW'(HS_STOP));
   assign hpos_o     = hc_q;

   generate
      if (HS_ACT) begin : g_hs_high
         assign hsync_o = hs_on;
      end else begin : g_hs_low
         assign hsync_o = ~hs_on;
      end
   endgenerate
endmodule

// File: rtl/vrg_vcount.sv
module vrg_vcount #(
   parameter int   V_ACTIVE = 200,
   parameter int   V_FRONT  = 2,
   parameter int   V_SYNC   = 3,
   parameter int   V_BACK   = 3,
   parameter int   HW       = 5,
   parameter int   H_HALF   = 12,
   localparam int  V_TOTAL  = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
   localparam int  VW       = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_end_i,
   input  logic [HW-1:0] hpos_i,
   input  logic          ilace_req_i,
   output logic [VW-1:0] vpos_o,
   output logic          v_act_o,
   output logic          vs_on_o,
   output logic          field_o,
   output logic          ilace_act_o,
   output logic          pass_end_o
);
   localparam int VS_START = V_ACTIVE + V_FRONT;
   localparam int VS_STOP  = VS_START + V_SYNC;

   logic [VW-1:0] vc_q;
   logic          field_q;
   logic          act_q;
   logic [HW-1:0] vs_off;
   logic          after_start;
   logic          before_stop;

   assign pass_end_o = line_end_i && (vc_q == VW'(V_TOTAL - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         vc_q    <= '0;
         field_q <= 1'b0;
         act_q   <= 1'b0;
      end else if (pass_end_o) begin
         vc_q    <= '0;
         act_q   <= ilace_req_i;
         field_q <= (ilace_req_i && act_q) ? ~field_q : 1'b0;
      end else if (line_end_i) begin
         vc_q    <= vc_q + 1'b1;
      end
   end

   // the offset field moves both vsync edges to mid-line
   assign vs_off      = field_q ? HW'(H_HALF) : '0;
   assign after_start = (vc_q > VW'(VS_START)) ||
                        ((vc_q == VW'(VS_START)) && (hpos_i >= vs_off));
   assign before_stop = (vc_q < VW'(VS_STOP)) ||
                        ((vc_q == VW'(VS_STOP)) && (hpos_i < vs_off));

   assign vs_on_o     = after_start && before_stop;
   assign v_act_o     = (vc_q < VW'(V_ACTIVE));
   assign vpos_o      = vc_q;
   assign field_o     = field_q;
   assign ilace_act_o = act_q;
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
   import vrg_pkg::*;
#(
   parameter int          H_ACTIVE  = 16,
   parameter int          H_FRONT   = 2,
   parameter int          H_SYNC    = 4,
   parameter int          H_BACK    = 2,
   parameter int          V_ACTIVE  = 200,
   parameter int          V_FRONT   = 2,
   parameter int          V_SYNC    = 3,
   parameter int          V_BACK    = 3,
   parameter bit          HS_ACT    = 1'b1,
   parameter bit          VS_ACT    = 1'b1,
   parameter int          RW        = 8,
   parameter logic [RW-1:0] CTRL_ADDR = 8'h05,
   localparam int         H_TOTAL   = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
   localparam int         V_TOTAL   = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
   localparam int         HW        = $clog2(H_TOTAL),
   localparam int         VW        = $clog2(V_TOTAL),
   localparam int         LW        = $clog2(2 * V_ACTIVE),
   localparam int         H_HALF    = H_TOTAL / 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          reg_wr_i,
   input  logic          reg_sel_i,
   input  logic [RW-1:0] reg_wdata_i,
   output logic [RW-1:0] reg_rdata_o,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic [LW-1:0] frame_line_o,
   output logic          field_o
);
   generate
      if (H_ACTIVE < 1 || H_SYNC < 1 || H_TOTAL < 4)
         $error("horizontal timing too short");
      if (V_ACTIVE < 1 || V_SYNC < 1 || V_BACK < 1)
         $error("vertical timing needs active, sync and back porch lines");
      if (RW < 1)
         $error("register width must be positive");
   endgenerate

   logic          ilace_req;
   logic          ilace_act;
   logic          pass_end;
   logic          line_end;
   logic          h_act;
   logic          v_act;
   logic          vs_on;
   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;

   vrg_regs #(.RW(RW), .CTRL_ADDR(CTRL_ADDR)) u_regs (
      .clk(clk), .rst(rst), .wr_i(reg_wr_i), .sel_i(reg_sel_i),
      .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .ilace_req_o(ilace_req)
   );

   vrg_hcount #(
      .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC),
      .H_BACK(H_BACK), .HS_ACT(HS_ACT)
   ) u_hc (
      .clk(clk), .rst(rst), .hpos_o(hpos), .h_act_o(h_act),
      .line_end_o(line_end), .hsync_o(hsync_o)
   );

   vrg_vcount #(
      .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC),
      .V_BACK(V_BACK), .HW(HW), .H_HALF(H_HALF)
   ) u_vc (
      .clk(clk), .rst(rst), .line_end_i(line_end), .hpos_i(hpos),
      .ilace_req_i(ilace_req), .vpos_o(vpos), .v_act_o(v_act),
      .vs_on_o(vs_on), .field_o(field_o), .ilace_act_o(ilace_act),
      .pass_end_o(pass_end)
   );

   generate
      if (VS_ACT) begin : g_vs_high
         assign vsync_o = vs_on;
      end else begin : g_vs_low
         assign vsync_o = ~vs_on;
      end
   endgenerate

   assign de_o = h_act && v_act;

   always_comb begin
      if (!v_act)
         frame_line_o = '0;
      else if (ilace_act)
         frame_line_o = LW'({vpos, (field_e'(field_o) == FIELD_ODD)});
      else
         frame_line_o = LW'(vpos);
   end
endmodule

// File: rtl/vrg_checker.sv
module vrg_checker #(
   parameter int H_ACTIVE = 16,
   parameter int H_FRONT  = 2,
   parameter int H_SYNC   = 4,
   parameter int H_BACK   = 2,
   parameter int V_ACTIVE = 200,
   parameter bit HS_ACT   = 1'b1,
   parameter int RW       = 8,
   localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
   localparam int HW      = $clog2(H_TOTAL),
   localparam int LW      = $clog2(2 * V_ACTIVE),
   localparam int H_HALF  = H_TOTAL / 2
) (
   input logic          clk,
   input logic          rst,
   input logic          de,
   input logic          hsync,
   input logic          field,
   input logic [LW-1:0] frame_line,
   input logic [RW-1:0] rdata,
   input logic          ilace_act,
   input logic          pass_end,
   input logic [HW-1:0] hpos,
   input logic          vs_on
);
   AST_DE_NO_HSYNC: assert property (@(posedge clk) disable iff (rst)
      de |-> (hsync == ~HS_ACT)); // R3

   AST_MODE_AT_PASS_END: assert property (@(posedge clk) disable iff (rst)
      (ilace_act != $past(ilace_act)) |-> $past(pass_end)); // R5

   AST_FIELD_AT_PASS_END: assert property (@(posedge clk) disable iff (rst)
      (field != $past(field)) |-> $past(pass_end)); // R6

   AST_FIELD_ZERO_PROG: assert property (@(posedge clk) disable iff (rst)
      !ilace_act |-> !field); // R6

   AST_LINE_PARITY: assert property (@(posedge clk) disable iff (rst)
      (ilace_act && de) |-> (frame_line[0] != field)); // R7

   AST_VS_MIDLINE: assert property (@(posedge clk) disable iff (rst)
      ($rose(vs_on) && field) |-> (hpos == HW'(H_HALF))); // R8

   AST_VS_LINESTART: assert property (@(posedge clk) disable iff (rst)
      ($rose(vs_on) && !field) |-> (hpos == '0)); // R2

   AST_RDATA_MASK: assert property (@(posedge clk) disable iff (rst)
      (rdata[RW-1:1] == '0)); // R4
endmodule

bind vid_raster_gen vrg_checker #(
   .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
   .V_ACTIVE(V_ACTIVE), .HS_ACT(HS_ACT), .RW(RW)
) u_chk (
   .clk(clk), .rst(rst), .de(de_o), .hsync(hsync_o), .field(field_o),
   .frame_line(frame_line_o), .rdata(reg_rdata_o), .ilace_act(ilace_act),
   .pass_end(pass_end), .hpos(hpos), .vs_on(vs_on)
);

// File: tb/tb_vid_raster_gen.sv
module tb_vid_raster_gen;
   localparam int HA = 16, HF = 2, HS = 4, HB = 2;
   localparam int VA = 200, VF = 2, VS = 3, VB = 3;
   localparam int HT = HA + HF + HS + HB;
   localparam int VT = VA + VF + VS + VB;
   localparam int PASS = HT * VT;
   localparam logic [7:0] CTRL = 8'h05;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       hsync, vsync, de, field;
   logic [8:0] frame_line;

   always #10 clk = ~clk;

   vid_raster_gen dut (
      .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hsync_o(hsync),
      .vsync_o(vsync), .de_o(de), .frame_line_o(frame_line), .field_o(field)
   );

   typedef struct {
      logic       hs, vs, de, fld, il, pend;
      logic [8:0] line;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   done   = 0;

   // predictor state
   int   mh, mv;
   bit   mf, mact, mreq;
   logic [7:0] maddr;
   bit   seen_il[2*VA];
   bit   seen_pr[VA];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic exp_t predict();
      exp_t e;
      int   off;
      off    = mf ? HT / 2 : 0;
      e.hs   = (mh >= HA + HF) && (mh < HA + HF + HS);
      e.vs   = ((mv > VA + VF) || (mv == VA + VF && mh >= off)) &&
               ((mv < VA + VF + VS) || (mv == VA + VF + VS && mh < off));
      e.de   = (mh < HA) && (mv < VA);
      e.fld  = mf;
      e.il   = mact;
      e.pend = (mreq != mact);
      if (mv >= VA)   e.line = '0;
      else if (mact)  e.line = 9'(2 * mv + (mf ? 0 : 1));
      else            e.line = 9'(mv);
      return e;
   endfunction

   // driver-side predictor: pushes one expected item per clock
   always begin
      @(posedge clk);
      #1;
      if (rst) begin
         mh = 0; mv = 0; mf = 0; mact = 0; mreq = 0; maddr = '0;
         q.delete();
      end else begin
         if (mh == HT - 1) begin
            mh = 0;
            if (mv == VT - 1) begin
               mv   = 0;
               mf   = (mreq && mact) ? !mf : 1'b0;
               mact = mreq;
            end else begin
               mv++;
            end
         end else begin
            mh++;
         end
         if (reg_wr && !reg_sel)                    maddr = reg_wdata;
         else if (reg_wr && reg_sel && maddr == CTRL) mreq = reg_wdata[0];
         q.push_back(predict());
      end
   end

   // monitor: pops and compares away from the active edge
   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         chk(hsync == e.hs, "R1 hsync", int'(hsync), int'(e.hs));
         chk(vsync == e.vs, e.fld ? "R8 vsync" : "R2 vsync", int'(vsync), int'(e.vs));
         chk(de == e.de, "R3 de", int'(de), int'(e.de));
         chk(field == e.fld, "R6 field", int'(field), int'(e.fld));
         chk(frame_line == e.line,
             e.pend ? "R5 line" : (e.il ? "R7 line" : "R2 line"),
             int'(frame_line), int'(e.line));
         if (de && e.de) begin
            if (e.il) seen_il[frame_line] = 1'b1;
            else if (frame_line < VA) seen_pr[frame_line] = 1'b1;
         end
      end
   end

   task automatic reg_write(input bit sel, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      int cnt;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(hsync == 1'b0 && vsync == 1'b0, "R10 syncs", int'({hsync, vsync}), 0);
      chk(de == 1'b1, "R10 de", int'(de), 1);
      chk(frame_line == '0 && field == 1'b0, "R10 line/field",
          int'({field, frame_line}), 0);
      chk(reg_rdata == 8'h00, "R10 rdata", int'(reg_rdata), 0);
      rst = 1'b0;

      run(2 * PASS);
      cnt = 0;
      foreach (seen_pr[i]) cnt += int'(seen_pr[i]);
      chk(cnt == VA, "R2 progressive coverage", cnt, VA);

      // enable interlace in mid-pass
      run(PASS / 3);
      reg_write(1'b0, CTRL);
      chk(reg_rdata == 8'h00, "R4 read ctrl clear", int'(reg_rdata), 0);
      reg_write(1'b1, 8'hFF);
      chk(reg_rdata == 8'h01, "R4 unused bits zero", int'(reg_rdata), 1);
      chk(field == 1'b0, "R5 no field before pass end", int'(field), 0);

      run(5 * PASS);
      cnt = 0;
      foreach (seen_il[i]) cnt += int'(seen_il[i]);
      chk(cnt == 2 * VA, "R9 interlaced coverage", cnt, 2 * VA);

      // unused pointer: reads zero, writes ignored
      reg_write(1'b0, 8'h03);
      chk(reg_rdata == 8'h00, "R4 other pointer reads zero", int'(reg_rdata), 0);
      reg_write(1'b1, 8'h00);
      reg_write(1'b0, CTRL);
      chk(reg_rdata == 8'h01, "R4 other pointer write ignored", int'(reg_rdata), 1);
      run(PASS);

      // back to progressive
      reg_write(1'b1, 8'h00);
      chk(reg_rdata == 8'h00, "R4 ctrl cleared", int'(reg_rdata), 0);
      run(2 * PASS + 10);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         summary();
         $finish;
      end
   end
endmodule